// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Controller

This block is the digital front end of a two-channel converter with 8-bit codes. A host sends 16-bit command words over a three-wire serial port: an active-low select, a serial clock and a data line. The three port signals are brought into a faster system clock domain, and every state change happens on that system clock. Each word carries a control byte first and a data byte second. Each control bit triggers exactly one action, and no combination of bits is decoded.

When the select line returns high after exactly sixteen serial clock rising edges, the block applies the word. It writes the data byte into the channel A holding register, the channel B holding register, or both. It also rewrites the sleep flag of each channel. For each channel the block presents the held code and a drive code. The drive code is zero while the channel sleeps. When the channel wakes, the drive code returns to the held code, which is kept through sleep.

Top module: `duo_dac_ctrl`

## Requirements
- R1: A frame is shifted most significant bit first. After sixteen bits, word bits 15..8 are the control byte and bits 7..0 are the data byte. The bit positions are: bit 8 loads channel A, bit 9 loads channel B, bit 11 is channel A sleep, bit 12 is channel B sleep. Bits 10, 13, 14 and 15 are spare.
- R2: When a valid frame has bit 8 set, the data byte is written to the channel A held code (`code_a_o`).
- R3: When a valid frame has bit 9 set, the data byte is written to the channel B held code. When bits 8 and 9 are both set, both channels receive the same byte in the same update.
- R4: Every valid frame sets `off_a_o` to bit 11 and `off_b_o` to bit 12, whether or not it loads data. The spare bits have no effect.
- R5: While a channel's sleep flag is 1, its drive code is 0 and its held code is unchanged. While the flag is 0, the drive code equals the held code.
- R6: A frame is applied only if exactly 16 serial clock rising edges occurred while select was low. Frames of 15 or 17 bits change no held code and no sleep flag.
- R7: Serial clock edges while select is high are ignored. The bit count restarts each time select falls.
- R8: A frame may be sent in several bursts with pauses in between, provided select stays low throughout. The result is the same as for one continuous burst.
- R9: Synchronous reset `rst` clears both held codes and both sleep flags. It also discards any partly received frame.
- R10: Outputs change only in response to a valid frame. The update appears no later than 4 system clock cycles after select rises at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| csn_i | input | 1 | Frame select, active low |
| din_i | input | 1 | Serial data in |
| code_a_o | output | DATA_W | Channel A held code |
| code_b_o | output | DATA_W | Channel B held code |
| drive_a_o | output | DATA_W | Channel A drive code, zero while asleep |
| drive_b_o | output | DATA_W | Channel B drive code, zero while asleep |
| off_a_o | output | 1 | Channel A sleep flag |
| off_b_o | output | 1 | Channel B sleep flag |

## Verification
If the bit counter is wrong, valid frames are dropped or truncated frames are applied. This shows on the held codes a few system cycles after select rises. If the shift order or field positions are wrong, the wrong channel is loaded or a bit-reversed byte appears at that same update, so every directed frame is compared with a model value right after select rises. If the sleep or restore logic is wrong, a drive code is nonzero while asleep or fails to return on wake. This is visible as soon as the sleep flag changes. Frames of 15 and 17 bits, split bursts and stray clocks with select high are each followed by a readback of all six outputs.

// File: rtl/duo_dac_pkg.sv
package duo_dac_pkg;

    localparam int CTRL_W = 8;
    localparam int NUM_CH = 2;

    // control byte, MSB is the first bit shifted in
    typedef struct packed {
        logic [2:0] spare_hi;
        logic       sleep_b;
        logic       sleep_a;
        logic       spare_lo;
        logic       load_b;
        logic       load_a;
    } ctrl_t;

    // synchronised port events in the system clock domain
    typedef struct packed {
        logic sclk_rise;
        logic cs_rise;
        logic cs_fall;
        logic cs_active;
        logic din;
    } port_ev_t;

    function automatic logic ch_load(ctrl_t c, int ch);
        return (ch == 0) ? c.load_a : c.load_b;
    endfunction

    function automatic logic ch_sleep(ctrl_t c, int ch);
        return (ch == 0) ? c.sleep_a : c.sleep_b;
    endfunction

endpackage

// File: rtl/duo_dac_sync.sv
module duo_dac_sync
    import duo_dac_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_i,
    input  logic     csn_i,
    input  logic     din_i,
    output port_ev_t ev_o
);
    // bit order {sclk, csn, din}; idle has select high
    localparam logic [2:0] IDLE = 3'b010;

    logic [2:0] chain [STAGES];
    logic       sclk_prev;
    logic       csn_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= IDLE;
                end else if (g == 0) begin
                    chain[g] <= {sclk_i, csn_i, din_i};
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= IDLE[2];
            csn_prev  <= IDLE[1];
        end else begin
            sclk_prev <= chain[STAGES-1][2];
            csn_prev  <= chain[STAGES-1][1];
        end
    end

    always_comb begin
        ev_o.sclk_rise = chain[STAGES-1][2] & ~sclk_prev;
        ev_o.cs_rise   = chain[STAGES-1][1] & ~csn_prev;
        ev_o.cs_fall   = ~chain[STAGES-1][1] & csn_prev;
        ev_o.cs_active = ~chain[STAGES-1][1];
        ev_o.din       = chain[STAGES-1][0];
    end

endmodule

// File: rtl/duo_dac_shifter.sv
module duo_dac_shifter
    import duo_dac_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  port_ev_t           ev_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   bit_cnt_o,
    output logic               frame_ok_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    logic             take_bit;
    logic [CNT_W-1:0] cnt_next;

    assign take_bit = ev_i.sclk_rise & ev_i.cs_active;
    assign cnt_next = (bit_cnt_o == CNT_SAT) ? CNT_SAT : bit_cnt_o + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_o   <= '0;
            bit_cnt_o <= '0;
        end else begin
            if (take_bit) begin
                frame_o <= {frame_o[FRAME_W-2:0], ev_i.din};
            end
            if (ev_i.cs_fall) begin
                bit_cnt_o <= take_bit ? CNT_W'(1) : '0;
            end else if (take_bit) begin
                bit_cnt_o <= cnt_next;
            end
        end
    end

    assign frame_ok_o = (bit_cnt_o == CNT_FULL);

endmodule

// File: rtl/duo_dac_regs.sv
module duo_dac_regs
    import duo_dac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          apply_i,
    input  ctrl_t                         ctrl_i,
    input  logic [DATA_W-1:0]             data_i,
    output logic [NUM_CH-1:0][DATA_W-1:0] code_o,
    output logic [NUM_CH-1:0][DATA_W-1:0] drive_o,
    output logic [NUM_CH-1:0]             sleep_o
);
    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst) begin
                    code_o[ch]  <= '0;
                    sleep_o[ch] <= 1'b0;
                end else if (apply_i) begin
                    if (ch_load(ctrl_i, ch)) begin
                        code_o[ch] <= data_i;
                    end
                    sleep_o[ch] <= ch_sleep(ctrl_i, ch);
                end
            end

            always_comb begin
                drive_o[ch] = sleep_o[ch] ? '0 : code_o[ch];
            end
        end
    endgenerate

endmodule

// File: rtl/duo_dac_ctrl.sv
module duo_dac_ctrl
    import duo_dac_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              din_i,
    output logic [DATA_W-1:0] code_a_o,
    output logic [DATA_W-1:0] code_b_o,
    output logic [DATA_W-1:0] drive_a_o,
    output logic [DATA_W-1:0] drive_b_o,
    output logic              off_a_o,
    output logic              off_b_o
);
    localparam int FRAME_W = CTRL_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    port_ev_t                       ev;
    logic [FRAME_W-1:0]             frame_w;
    logic [CNT_W-1:0]               bit_cnt;
    logic                           frame_ok;
    logic                           apply;
    logic                           cs_rise;
    logic                           cs_fall;
    ctrl_t                          ctrl;
    logic [NUM_CH-1:0][DATA_W-1:0]  code;
    logic [NUM_CH-1:0][DATA_W-1:0]  drive;
    logic [NUM_CH-1:0]              sleep;

    duo_dac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .csn_i  (csn_i),
        .din_i  (din_i),
        .ev_o   (ev)
    );

    duo_dac_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .frame_o    (frame_w),
        .bit_cnt_o  (bit_cnt),
        .frame_ok_o (frame_ok)
    );

    assign cs_rise = ev.cs_rise;
    assign cs_fall = ev.cs_fall;
    assign apply   = cs_rise & frame_ok;
    assign ctrl    = ctrl_t'(frame_w[FRAME_W-1:DATA_W]);

    duo_dac_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .apply_i (apply),
        .ctrl_i  (ctrl),
        .data_i  (frame_w[DATA_W-1:0]),
        .code_o  (code),
        .drive_o (drive),
        .sleep_o (sleep)
    );

    assign code_a_o  = code[0];
    assign code_b_o  = code[1];
    assign drive_a_o = drive[0];
    assign drive_b_o = drive[1];
    assign off_a_o   = sleep[0];
    assign off_b_o   = sleep[1];

endmodule

// File: rtl/duo_dac_chk.sv
module duo_dac_chk #(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               cs_rise,
    input logic               cs_fall,
    input logic [CNT_W-1:0]   bit_cnt,
    input logic [FRAME_W-1:0] frame_w,
    input logic [DATA_W-1:0]  code_a_o,
    input logic [DATA_W-1:0]  code_b_o,
    input logic [DATA_W-1:0]  drive_a_o,
    input logic [DATA_W-1:0]  drive_b_o,
    input logic               off_a_o,
    input logic               off_b_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    assert_codes_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> ($stable(code_a_o) && $stable(code_b_o)));

    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> ($stable(off_a_o) && $stable(off_b_o)));

    assert_bad_count_R6: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && bit_cnt != FULL) |=>
            ($stable(code_a_o) && $stable(code_b_o) && $stable(off_a_o) && $stable(off_b_o)));

    assert_count_restart_R7: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (bit_cnt <= CNT_W'(1)));

    assert_both_same_R3: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && bit_cnt == FULL && frame_w[DATA_W] && frame_w[DATA_W+1]) |=>
            (code_a_o == code_b_o));

    assert_sleep_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (off_a_o ? (drive_a_o == '0) : (drive_a_o == code_a_o)) &&
        (off_b_o ? (drive_b_o == '0) : (drive_b_o == code_b_o)));

    assert_load_a_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && bit_cnt == FULL && frame_w[DATA_W]) |=>
            (code_a_o == $past(frame_w[DATA_W-1:0])));

endmodule

bind duo_dac_ctrl duo_dac_chk #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .bit_cnt   (bit_cnt),
    .frame_w   (frame_w),
    .code_a_o  (code_a_o),
    .code_b_o  (code_b_o),
    .drive_a_o (drive_a_o),
    .drive_b_o (drive_b_o),
    .off_a_o   (off_a_o),
    .off_b_o   (off_b_o)
);

// File: tb/test_duo_dac_ctrl.sv
module test_duo_dac_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;
    localparam int DW         = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic csn = 1'b1;
    logic din = 1'b0;
    logic [DW-1:0] code_a, code_b, drive_a, drive_b;
    logic off_a, off_b;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] m_a = '0, m_b = '0;
    logic          m_oa = 1'b0, m_ob = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    duo_dac_ctrl #(.DATA_W(DW)) i_duo_dac_ctrl (
        .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .din_i(din),
        .code_a_o(code_a), .code_b_o(code_b),
        .drive_a_o(drive_a), .drive_b_o(drive_b),
        .off_a_o(off_a), .off_b_o(off_b)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_val(input string req, input string what,
                             input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check_val(req, "code_a", code_a, m_a);
        check_val(req, "code_b", code_b, m_b);
        check_val(req, "off_a", {7'd0, off_a}, {7'd0, m_oa});
        check_val(req, "off_b", {7'd0, off_b}, {7'd0, m_ob});
        check_val(req, "drive_a", drive_a, m_oa ? '0 : m_a);
        check_val(req, "drive_b", drive_b, m_ob ? '0 : m_b);
    endtask

    // R1 bit map: 8 load A, 9 load B, 11 sleep A, 12 sleep B
    task automatic model(input logic [15:0] w);
        if (w[8]) m_a = w[7:0];
        if (w[9]) m_b = w[7:0];
        m_oa = w[11];
        m_ob = w[12];
    endtask

    task automatic shift(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            din = w[i];
            idle(HALF_SCLK);
            sclk = 1'b1;
            idle(HALF_SCLK);
            sclk = 1'b0;
        end
    endtask

    task automatic frame(input logic [31:0] w, input int n);
        csn = 1'b0;
        idle(HALF_SCLK);
        shift(w, n);
        idle(HALF_SCLK);
        csn = 1'b1;
        idle(4); // R10 latency bound
    endtask

    task automatic send(input logic [15:0] w, input string req);
        frame({16'd0, w}, 16);
        model(w);
        check_all(req);
    endtask

    task automatic t_reset;
        check_all("R9");
    endtask

    task automatic t_loads;
        send(16'h015A, "R2");          // R1 field order, R2 load A
        send(16'h02C3, "R3");          // load B only
        send(16'h0380, "R3");          // both channels same value
    endtask

    task automatic t_sleep;
        send(16'h0877, "R5");          // sleep A, no load: code A held, drive 0
        send(16'h1A11, "R4");          // sleep both and load B
        send(16'h0000, "R5");          // wake: drive restored
    endtask

    task automatic t_spare;
        send(16'hE53C, "R4");          // spare bits set plus load A: no sleep
    endtask

    task automatic t_bad_count;
        frame(32'h00007FF, 15);        // R6 15 bits: no change
        check_all("R6");
        frame(32'h0001BFFF, 17);       // R6 17 bits: no change
        check_all("R6");
    endtask

    task automatic t_split;
        csn = 1'b0;
        idle(HALF_SCLK);
        shift(32'h03, 8);
        idle(40);
        shift(32'hA5, 8);
        idle(HALF_SCLK);
        csn = 1'b1;
        idle(4);
        model(16'h03A5);
        check_all("R8");
    endtask

    task automatic t_stray;
        for (int i = 0; i < 5; i++) begin
            din = 1'b1;
            idle(HALF_SCLK);
            sclk = 1'b1;
            idle(HALF_SCLK);
            sclk = 1'b0;
        end
        check_all("R7");
        send(16'h0142, "R7");
    endtask

    task automatic t_reset_mid;
        csn = 1'b0;
        idle(HALF_SCLK);
        shift(32'h03, 8);
        rst = 1'b1;
        csn = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(4);
        m_a = '0; m_b = '0; m_oa = 1'b0; m_ob = 1'b0;
        check_all("R9");
        send(16'h0199, "R9");
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        idle(4);
        t_reset();
        t_loads();
        t_sleep();
        t_spare();
        t_bad_count();
        t_split();
        t_stray();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule